// File: doc/BRIEF.md
# Interrupt-Capable GPIO Controller

This block is a general-purpose I/O peripheral behind a 32-bit register port. Software drives each pin through a direction register and an output-data register. It reads the synchronised pin levels through an input register. A fixed window of consecutive pins can also act as interrupt sources. Each pin in that window has a function-select bit that switches it into interrupt mode, and a polarity bit that says whether a high or a low level is active. The block turns every enabled window pin into an active-high interrupt line for a downstream interrupt controller. That controller does the edge capture, masking and acknowledge.

The register port is a single-cycle request channel: `req_valid`, `req_write`, `req_addr`, `req_wdata`. It applies no back-pressure, so every request presented with `req_valid` high is taken at that clock edge. A read answers one cycle later with `rsp_valid` high and `rsp_rdata` holding the result. The consumer of the response must accept it in that cycle, because the block does not stall or store responses. Pins are shown as separate input, output and output-enable vectors, and the pad sits outside the block.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, every register reads zero, `gpio_oe` and `gpio_out` are all zero and every `irq_out` bit is low.
- R2: A write to the direction register (offset 0x29C) or the output-data register (offset 0x2A0) shows up on `gpio_oe` and `gpio_out` (bit i drives pin i) in the cycle after the write edge.
- R3: A read request gives `rsp_valid` high in the next cycle, and never otherwise. The registers at 0x290 (polarity), 0x294 (function select), 0x29C and 0x2A0 return all 32 bits last written to them.
- R4: Offset 0x2A4 returns the level of pin i in bit i, with bits above the last pin reading zero. The level passes through two synchronising flops, so it is visible after two clock edges. Writes to 0x2A4 change nothing.
- R5: A write to any other address, including offsets that are not 4-byte aligned, changes no register, and a read from such an address returns zero.
- R6: Interrupt line n belongs to pin n+8, for n from 0 to 5. Pins outside 8..13 never affect any interrupt line.
- R7: With function-select bit (2*(n+8)) mod 32 set, `irq_out[n]` equals the synchronised level of pin n+8 when polarity bit n is 1, and its inverse when polarity bit n is 0.
- R8: With function-select bit (2*(n+8)) mod 32 clear, `irq_out[n]` stays low whatever the pin level and polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register request present, always accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | 32 | Read data |
| gpio_in | input | 22 | Pin levels from the pads, asynchronous |
| gpio_out | output | 22 | Output data to the pads |
| gpio_oe | output | 22 | Output enable per pin, 0 = tri-stated |
| irq_out | output | 6 | Active-high interrupt lines for pins 8..13 |

## Verification
A register write to the polarity or function-select register can land on the same clock edge as a pin change entering the synchroniser. The new configuration and the new pin level then meet at the interrupt output. The bench drives a polarity write and a window-pin change in the same cycle, and also a function-select enable together with a pin edge. Once both have settled, it compares `irq_out` with the value worked out from the written configuration and the pin pattern. A read of the input register issued while a pin changes is judged against the two-edge synchroniser latency.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned ADDR_W  = 12;
  localparam int unsigned DATA_W  = 32;

  localparam logic [ADDR_W-1:0] OFS_POL  = 12'h290;
  localparam logic [ADDR_W-1:0] OFS_FUNC = 12'h294;
  localparam logic [ADDR_W-1:0] OFS_DIR  = 12'h29C;
  localparam logic [ADDR_W-1:0] OFS_DOUT = 12'h2A0;
  localparam logic [ADDR_W-1:0] OFS_DIN  = 12'h2A4;

  typedef enum logic [2:0] {
    RSEL_NONE,
    RSEL_POL,
    RSEL_FUNC,
    RSEL_DIR,
    RSEL_DOUT,
    RSEL_DIN
  } reg_sel_e;

  function automatic reg_sel_e decode_ofs(input logic [ADDR_W-1:0] a);
    case (a)
      OFS_POL:  return RSEL_POL;
      OFS_FUNC: return RSEL_FUNC;
      OFS_DIR:  return RSEL_DIR;
      OFS_DOUT: return RSEL_DOUT;
      OFS_DIN:  return RSEL_DIN;
      default:  return RSEL_NONE;
    endcase
  endfunction

  // Function-select bit that enables interrupt mode for a pin.
  function automatic int unsigned func_bit(input int unsigned pin);
    return (pin * 2) % DATA_W;
  endfunction
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned NUM_PINS = 22
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_async,
  output logic [NUM_PINS-1:0] pin_sync
);
  logic [NUM_PINS-1:0] meta_q;
  logic [NUM_PINS-1:0] sync_q;
  logic [1:0]          warm_q;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[i] <= 1'b0;
        sync_q[i] <= 1'b0;
      end else begin
        meta_q[i] <= pin_async[i];
        sync_q[i] <= meta_q[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warm_q <= 2'd0;
    else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
  end

  assign pin_sync = sync_q;

  // R4: synchronised level equals the pin level two edges earlier
  assert_sync_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 2'd2) |-> (pin_sync == $past(pin_async, 2)));
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS = 22,
  parameter int unsigned IRQ_BASE = 8,
  parameter int unsigned NUM_IRQ  = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic                rsp_valid,
  output logic [DATA_W-1:0]   rsp_rdata,
  input  logic [NUM_PINS-1:0] pin_sync,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic [NUM_PINS-1:0] pin_dout,
  output logic [NUM_IRQ-1:0]  irq_en,
  output logic [NUM_IRQ-1:0]  irq_pol
);
  logic [DATA_W-1:0] pol_q, func_q, dir_q, dout_q;
  logic [DATA_W-1:0] din_ext, rd_mux;
  reg_sel_e          sel;
  logic              wr_en, rd_en, rd_miss_q;

  assign sel   = decode_ofs(req_addr);
  assign wr_en = req_valid && req_write;
  assign rd_en = req_valid && !req_write;

  always_comb begin
    din_ext = '0;
    din_ext[NUM_PINS-1:0] = pin_sync;
  end

  always_comb begin
    case (sel)
      RSEL_POL:  rd_mux = pol_q;
      RSEL_FUNC: rd_mux = func_q;
      RSEL_DIR:  rd_mux = dir_q;
      RSEL_DOUT: rd_mux = dout_q;
      RSEL_DIN:  rd_mux = din_ext;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q  <= '0;
      func_q <= '0;
      dir_q  <= '0;
      dout_q <= '0;
    end else if (wr_en) begin
      case (sel)
        RSEL_POL:  pol_q  <= req_wdata;
        RSEL_FUNC: func_q <= req_wdata;
        RSEL_DIR:  dir_q  <= req_wdata;
        RSEL_DOUT: dout_q <= req_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rd_miss_q <= 1'b0;
    end else begin
      rsp_valid <= rd_en;
      rd_miss_q <= rd_en && (sel == RSEL_NONE);
      if (rd_en) rsp_rdata <= rd_mux;
    end
  end

  assign pin_oe   = dir_q[NUM_PINS-1:0];
  assign pin_dout = dout_q[NUM_PINS-1:0];

  for (genvar n = 0; n < NUM_IRQ; n++) begin : g_irq_cfg
    assign irq_en[n]  = func_q[func_bit(IRQ_BASE + n)];
    assign irq_pol[n] = pol_q[n];
  end

  // R3: a response follows exactly the cycles after a read request
  assert_rsp_timing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rsp_valid);
  assert_no_spurious_rsp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rsp_valid);
  // R5: unmapped reads return zero
  assert_unmapped_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rd_miss_q) |-> (rsp_rdata == '0));
  // R5: registers stay still unless a write hits them
  assert_pol_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && sel == RSEL_POL) |=> $stable(pol_q));
endmodule

// File: rtl/gpio_irq_norm.sv
module gpio_irq_norm #(
  parameter int unsigned NUM_IRQ = 6
) (
  input  logic [NUM_IRQ-1:0] win_pins,
  input  logic [NUM_IRQ-1:0] irq_en,
  input  logic [NUM_IRQ-1:0] irq_pol,
  output logic [NUM_IRQ-1:0] irq_out
);
  for (genvar n = 0; n < NUM_IRQ; n++) begin : g_line
    logic active;
    // Polarity 1: high level active; polarity 0: low level active.
    assign active     = irq_pol[n] ? win_pins[n] : ~win_pins[n];
    assign irq_out[n] = irq_en[n] & active;
  end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS = 22,
  parameter int unsigned IRQ_BASE = 8,
  parameter int unsigned NUM_IRQ  = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic                rsp_valid,
  output logic [DATA_W-1:0]   rsp_rdata,
  input  logic [NUM_PINS-1:0] gpio_in,
  output logic [NUM_PINS-1:0] gpio_out,
  output logic [NUM_PINS-1:0] gpio_oe,
  output logic [NUM_IRQ-1:0]  irq_out
);
  logic [NUM_PINS-1:0] pin_sync;
  logic [NUM_IRQ-1:0]  irq_en, irq_pol;

  gpio_in_sync #(.NUM_PINS(NUM_PINS)) sync_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_async (gpio_in),
    .pin_sync  (pin_sync)
  );

  gpio_regfile #(
    .NUM_PINS (NUM_PINS),
    .IRQ_BASE (IRQ_BASE),
    .NUM_IRQ  (NUM_IRQ)
  ) regs_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .pin_sync  (pin_sync),
    .pin_oe    (gpio_oe),
    .pin_dout  (gpio_out),
    .irq_en    (irq_en),
    .irq_pol   (irq_pol)
  );

  gpio_irq_norm #(.NUM_IRQ(NUM_IRQ)) norm_i (
    .win_pins (pin_sync[IRQ_BASE +: NUM_IRQ]),
    .irq_en   (irq_en),
    .irq_pol  (irq_pol),
    .irq_out  (irq_out)
  );

  // R2: pin direction changes only after a write to the direction register
  assert_dir_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_write && req_addr == OFS_DIR) |=> $stable(gpio_oe));

  for (genvar n = 0; n < NUM_IRQ; n++) begin : g_chk
    // R8: a line whose pin is not in interrupt mode stays low
    assert_irq_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en[n] |-> !irq_out[n]);
  end
endmodule

// File: tb/gpio_irq_ctrl_tb.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_tb_top;
  localparam int NP = 22;
  localparam int NI = 6;
  localparam int BASE = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic rsp_valid;
  logic [31:0] rsp_rdata;
  logic [NP-1:0] gpio_in = '0;
  logic [NP-1:0] gpio_out, gpio_oe;
  logic [NI-1:0] irq_out;

  int errors = 0;
  int checks = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  gpio_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .gpio_in(gpio_in), .gpio_out(gpio_out), .gpio_oe(gpio_oe),
    .irq_out(irq_out)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on each response.
  always @(posedge clk) begin
    #1;
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        check("R3 unexpected response", 32'd1, 32'd0);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(t, rsp_rdata, e);
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic wr_pins(input logic [11:0] a, input logic [31:0] d, input logic [NP-1:0] p);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; gpio_in = p;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Expected interrupt lines from configuration and pin levels (R6, R7, R8).
  function automatic logic [NI-1:0] model_irq(input logic [31:0] fsel, input logic [31:0] pol,
                                              input logic [NP-1:0] pins);
    logic [NI-1:0] r;
    for (int n = 0; n < NI; n++) begin
      logic lvl;
      lvl = pins[BASE + n];
      r[n] = fsel[((BASE + n) * 2) % 32] && (pol[n] ? lvl : !lvl);
    end
    return r;
  endfunction

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] fs, pl;
    logic [NP-1:0] pins;
    settle(3);
    rst_n = 1'b1;
    settle(1);
    // R1 reset state
    check("R1 gpio_oe", 32'(gpio_oe), 32'd0);
    check("R1 gpio_out", 32'(gpio_out), 32'd0);
    check("R1 irq_out", 32'(irq_out), 32'd0);
    rd(12'h290, 32'd0, "R1 polarity reset");
    rd(12'h294, 32'd0, "R1 func reset");
    rd(12'h29C, 32'd0, "R1 dir reset");
    rd(12'h2A0, 32'd0, "R1 dout reset");

    // R2 pin drive
    wr(12'h29C, 32'hA5A5_00FF);
    check("R2 gpio_oe", 32'(gpio_oe), 32'h0025_00FF);
    wr(12'h2A0, 32'h1234_5678);
    check("R2 gpio_out", 32'(gpio_out), 32'h0034_5678);

    // R3 full-width readback
    rd(12'h29C, 32'hA5A5_00FF, "R3 dir readback");
    rd(12'h2A0, 32'h1234_5678, "R3 dout readback");
    wr(12'h290, 32'hFFFF_FFC3);
    wr(12'h294, 32'h8555_5551);
    rd(12'h290, 32'hFFFF_FFC3, "R3 polarity readback");
    rd(12'h294, 32'h8555_5551, "R3 func readback");

    // R4 input path
    gpio_in = 22'h2A_5A3C;
    settle(3);
    rd(12'h2A4, 32'h002A_5A3C, "R4 input read");
    wr(12'h2A4, 32'hFFFF_FFFF);
    rd(12'h2A4, 32'h002A_5A3C, "R4 input write ignored");
    // R4 latency: change pins, read on the edge right after
    @(negedge clk);
    gpio_in = 22'h3F_FFFF;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 12'h2A4;
    exp_q.push_back(32'h002A_5A3C); tag_q.push_back("R4 one edge old");
    @(negedge clk);
    exp_q.push_back(32'h002A_5A3C); tag_q.push_back("R4 sync stage 2");
    @(negedge clk);
    exp_q.push_back(32'h003F_FFFF); tag_q.push_back("R4 after two edges");
    @(negedge clk);
    req_valid = 1'b0;

    // R5 unmapped addresses
    wr(12'h298, 32'hFFFF_FFFF);
    wr(12'h291, 32'h0000_0000);
    wr(12'h2A1, 32'h0000_0000);
    rd(12'h298, 32'd0, "R5 unmapped read");
    rd(12'h291, 32'd0, "R5 misaligned read");
    rd(12'h290, 32'hFFFF_FFC3, "R5 polarity untouched");
    rd(12'h2A0, 32'h1234_5678, "R5 dout untouched");

    // R8 function select off
    wr(12'h294, 32'h0);
    wr(12'h290, 32'h0);
    gpio_in = '0;
    settle(3);
    check("R8 irq off low-active pins", 32'(irq_out), 32'd0);

    // R6/R7 window enabled, high-active
    fs = 32'h0555_0000;
    pl = 32'h3F;
    wr(12'h294, fs);
    wr(12'h290, pl);
    pins = 22'h00_2D00;
    gpio_in = pins;
    settle(3);
    check("R7 high active", 32'(irq_out), 32'(model_irq(fs, pl, pins)));
    check("R6 pin mapping", 32'(irq_out), 32'h2D);
    pl = 32'h0;
    wr(12'h290, pl);
    check("R7 low active", 32'(irq_out), 32'h12);
    // R6 neighbours of the window
    pins = pins | 22'h3F_C0FF;
    pins[BASE +: NI] = 6'h2D;
    gpio_in = pins;
    settle(3);
    check("R6 outside pins no effect", 32'(irq_out), 32'h12);
    // R8 one line disabled (pin 9 -> bit 18)
    fs = 32'h0551_0000;
    wr(12'h294, fs);
    check("R8 line disabled", 32'(irq_out), 32'(model_irq(fs, pl, pins)));

    // Concurrent: polarity write with window pin change in the same cycle
    pl = 32'h15;
    pins[BASE +: NI] = 6'h33;
    wr_pins(12'h290, pl, pins);
    settle(2);
    check("R7 concurrent write and pin change", 32'(irq_out), 32'(model_irq(fs, pl, pins)));
    fs = 32'h0555_0000;
    pins[BASE +: NI] = 6'h0C;
    wr_pins(12'h294, fs, pins);
    settle(2);
    check("R7 enable with pin edge", 32'(irq_out), 32'(model_irq(fs, pl, pins)));

    settle(3);
    check("R3 scoreboard drained", 32'(exp_q.size()), 32'd0);
    finish_run();
  end
endmodule